// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

This block is one cell of a programmable logic fabric. It takes a group of product terms, keeps the ones its configuration selects and ORs them into one sum term. An optional inversion follows. The result goes into a single storage element. That element can be configured to act as a wire, an edge-triggered D or T flip-flop, or a level-sensitive latch.

The element is timed by one of several global clock enables, sampled on the fabric clock `clk`. An asynchronous clear and an asynchronous set can force it at any time. The cell drives a pin value and a pin enable. It also returns a feedback copy of its state to the routing fabric, and that copy does not depend on whether the pin is driven.

A parameter selects the buried variant. That variant has no pin drive. In exchange it can use its storage element as an input register or input latch for the value of a neighbouring pin.

The configuration inputs are loaded while `arst` is high and held constant afterwards.

Top module: `lgc_macrocell`

## Requirements
- R1: The sum term is the OR of `pterms` bits whose `cfg_term_mask` bit is 1. An all-zero mask yields 0 before inversion.
- R2: When `cfg_invert` is 1 the sum term is inverted before it reaches the storage element.
- R3: Mode code 0 (wire) passes the polarity-adjusted sum term straight to the outputs in the same cycle, and `arst`/`apre` have no effect on it.
- R4: Mode code 1 (D flip-flop) loads the data on a `clk` rising edge where the selected global enable is 1, and holds otherwise.
- R5: Mode code 2 (T flip-flop) inverts its state on a `clk` rising edge where the selected enable is 1 and the data is 1. It holds when the data is 0.
- R6: Mode code 3 (latch) shows the data while the selected enable is 1 and keeps the last value seen while it is 0.
- R7: `cfg_clk_sel` is an index into `gclk_en`. An enable bit that is not selected has no effect on the storage element.
- R8: In every mode except the wire, `arst` forces the state to 0 and `apre` forces it to 1 without waiting for a clock. If both are high, 0 wins.
- R9: In the pin variant, `pin_out` equals `fb_out` and `pin_oe` follows `oe_term`. `fb_out` keeps tracking the state while `pin_oe` is 0.
- R10: In the buried variant, `pin_out` and `pin_oe` stay 0. `fb_out` carries the state in every mode.
- R11: In the buried variant with `cfg_inreg` = 1, the element stores `pin_in` without inversion and ignores the sum term. It acts as a D register when `cfg_inreg_latch` is 0 and as a latch when it is 1, whatever `cfg_mode` holds.
- R12: In the pin variant, `cfg_inreg` and `cfg_inreg_latch` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| arst | input | 1 | Asynchronous clear, active high |
| apre | input | 1 | Asynchronous set, active high |
| pterms | input | N_TERMS | Product terms offered to the cell |
| gclk_en | input | N_GCLK | Global clock / latch enables |
| oe_term | input | 1 | Pin drive enable term |
| pin_in | input | 1 | Neighbouring pin value (buried input register) |
| cfg_term_mask | input | N_TERMS | Product terms that take part in the sum |
| cfg_invert | input | 1 | Invert the sum term |
| cfg_mode | input | 2 | 0 wire, 1 D, 2 T, 3 latch |
| cfg_clk_sel | input | SEL_W | Index of the global enable in use |
| cfg_inreg | input | 1 | Buried only: store the pin value |
| cfg_inreg_latch | input | 1 | Buried only: input latch instead of input register |
| pin_out | output | 1 | Value driven to the pin |
| pin_oe | output | 1 | Pin drive enable |
| fb_out | output | 1 | Feedback to the routing fabric |

## Verification
Each storage mode is exercised with data that sets, clears and holds the state. This separates loading from holding, and toggling from holding. Product terms outside the mask are raised on their own to confirm they cannot reach the sum. Pulses on the global enable that is not selected confirm it has no effect. Set and clear pulses are applied alone and together, in both a storage mode and the wire mode, which shows the priority and the exemption. In the input-register cases the pin variant and the buried variant share the same stimulus, so their different outputs show that the pin value reaches only the buried cell.

// File: rtl/mc_pkg.sv
package mc_pkg;
   typedef enum logic [1:0] {
      MC_COMB  = 2'd0,
      MC_DFF   = 2'd1,
      MC_TFF   = 2'd2,
      MC_LATCH = 2'd3
   } mc_mode_e;
endpackage

// File: rtl/mc_sum_term.sv
module mc_sum_term #(
   parameter int N_TERMS = 16
) (
   input  logic [N_TERMS-1:0] pterms,
   input  logic [N_TERMS-1:0] mask,
   input  logic               invert,
   output logic               sum_pol
);
   logic [N_TERMS-1:0] kept;
   logic               sum_raw;

   genvar gi;
   generate
      for (gi = 0; gi < N_TERMS; gi++) begin : g_keep
         assign kept[gi] = pterms[gi] & mask[gi];
      end
   endgenerate

   assign sum_raw = |kept;
   assign sum_pol = sum_raw ^ invert;
endmodule

// File: rtl/mc_clk_pick.sv
module mc_clk_pick #(
   parameter int N_GCLK = 2,
   localparam int SEL_W = (N_GCLK > 1) ? $clog2(N_GCLK) : 1
) (
   input  logic [N_GCLK-1:0] gclk_en,
   input  logic [SEL_W-1:0]  sel,
   output logic              tick
);
   generate
      if (N_GCLK == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^sel;
         assign tick = gclk_en[0];
      end else begin : g_multi
         always_comb begin
            tick = 1'b0;
            for (int i = 0; i < N_GCLK; i++) begin
               if (sel == SEL_W'(i)) tick = gclk_en[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mc_store.sv
module mc_store
   import mc_pkg::*;
(
   input  logic     clk,
   input  logic     arst,
   input  logic     apre,
   input  mc_mode_e mode,
   input  logic     d,
   input  logic     tick,
   output logic     q_out
);
   logic q;

   always_ff @(posedge clk or posedge arst or posedge apre) begin
      if (arst)      q <= 1'b0;
      else if (apre) q <= 1'b1;
      else if (tick) begin
         case (mode)
            MC_DFF:   q <= d;
            MC_TFF:   q <= q ^ d;
            MC_LATCH: q <= d;
            default:  q <= q;
         endcase
      end
   end

   always_comb begin
      if (mode == MC_COMB)            q_out = d;
      else if (arst)                  q_out = 1'b0;
      else if (apre)                  q_out = 1'b1;
      else if (mode == MC_LATCH && tick) q_out = d;
      else                            q_out = q;
   end
endmodule

// File: rtl/lgc_macrocell.sv
module lgc_macrocell
   import mc_pkg::*;
#(
   parameter int N_TERMS = 16,
   parameter int N_GCLK  = 2,
   parameter bit BURIED  = 1'b0,
   localparam int SEL_W  = (N_GCLK > 1) ? $clog2(N_GCLK) : 1
) (
   input  logic               clk,
   input  logic               arst,
   input  logic               apre,
   input  logic [N_TERMS-1:0] pterms,
   input  logic [N_GCLK-1:0]  gclk_en,
   input  logic               oe_term,
   input  logic               pin_in,
   input  logic [N_TERMS-1:0] cfg_term_mask,
   input  logic               cfg_invert,
   input  logic [1:0]         cfg_mode,
   input  logic [SEL_W-1:0]   cfg_clk_sel,
   input  logic               cfg_inreg,
   input  logic               cfg_inreg_latch,
   output logic               pin_out,
   output logic               pin_oe,
   output logic               fb_out
);
   generate
      if (N_TERMS < 1 || N_TERMS > 64) begin : g_bad_terms
         $error("lgc_macrocell: N_TERMS must lie in 1..64");
      end
      if (N_GCLK < 1 || N_GCLK > 8) begin : g_bad_gclk
         $error("lgc_macrocell: N_GCLK must lie in 1..8");
      end
   endgenerate

   logic     sum_pol;
   logic     tick;
   logic     store_d;
   mc_mode_e store_mode;
   logic     state;

   mc_sum_term #(.N_TERMS(N_TERMS)) u_sum (
      .pterms (pterms),
      .mask   (cfg_term_mask),
      .invert (cfg_invert),
      .sum_pol(sum_pol)
   );

   mc_clk_pick #(.N_GCLK(N_GCLK)) u_clk (
      .gclk_en(gclk_en),
      .sel    (cfg_clk_sel),
      .tick   (tick)
   );

   generate
      if (BURIED) begin : g_buried
         logic unused_oe;
         assign unused_oe  = oe_term;
         assign store_d    = cfg_inreg ? pin_in : sum_pol;
         assign store_mode = cfg_inreg ? (cfg_inreg_latch ? MC_LATCH : MC_DFF)
                                       : mc_mode_e'(cfg_mode);
         assign pin_out    = 1'b0;
         assign pin_oe     = 1'b0;
      end else begin : g_pin
         logic unused_inreg;
         assign unused_inreg = ^{pin_in, cfg_inreg, cfg_inreg_latch};
         assign store_d    = sum_pol;
         assign store_mode = mc_mode_e'(cfg_mode);
         assign pin_out    = state;
         assign pin_oe     = oe_term;
      end
   endgenerate

   mc_store u_store (
      .clk  (clk),
      .arst (arst),
      .apre (apre),
      .mode (store_mode),
      .d    (store_d),
      .tick (tick),
      .q_out(state)
   );

   assign fb_out = state;
endmodule

// File: rtl/mc_checker.sv
module mc_checker
   import mc_pkg::*;
#(
   parameter int N_TERMS = 16,
   parameter int N_GCLK  = 2,
   parameter bit BURIED  = 1'b0,
   localparam int SEL_W  = (N_GCLK > 1) ? $clog2(N_GCLK) : 1
) (
   input logic               clk,
   input logic               arst,
   input logic               apre,
   input logic [N_TERMS-1:0] pterms,
   input logic [N_GCLK-1:0]  gclk_en,
   input logic               pin_in,
   input logic [N_TERMS-1:0] cfg_term_mask,
   input logic               cfg_invert,
   input logic [1:0]         cfg_mode,
   input logic [SEL_W-1:0]   cfg_clk_sel,
   input logic               cfg_inreg,
   input logic               cfg_inreg_latch,
   input logic               pin_out,
   input logic               pin_oe,
   input logic               fb_out
);
   logic       use_pin;
   logic [1:0] eff_mode;
   logic       eff_d;
   logic       sel_en;

   assign use_pin  = BURIED && cfg_inreg;
   assign eff_mode = use_pin ? (cfg_inreg_latch ? 2'd3 : 2'd1) : cfg_mode;
   assign eff_d    = use_pin ? pin_in : ((|(pterms & cfg_term_mask)) ^ cfg_invert);

   always_comb begin
      sel_en = 1'b0;
      for (int i = 0; i < N_GCLK; i++) begin
         if (cfg_clk_sel == SEL_W'(i)) sel_en = gclk_en[i];
      end
   end

   p_empty_sum_r1: assert property (@(posedge clk) disable iff (arst)
      (cfg_term_mask == '0 && eff_mode == 2'd0) |-> (fb_out == cfg_invert));

   p_dff_hold_r4: assert property (@(posedge clk) disable iff (arst || apre)
      (eff_mode == 2'd1 && !sel_en) |=> (fb_out == $past(fb_out)));

   p_tff_flip_r5: assert property (@(posedge clk) disable iff (arst || apre)
      (eff_mode == 2'd2 && sel_en && eff_d) |=> (fb_out != $past(fb_out)));

   p_latch_open_r6: assert property (@(posedge clk) disable iff (arst || apre)
      (eff_mode == 2'd3 && sel_en) |-> (fb_out == eff_d));

   p_clear_r8: assert property (@(posedge clk) disable iff (1'b0)
      (arst && eff_mode != 2'd0) |-> (fb_out == 1'b0));

   p_set_r8: assert property (@(posedge clk) disable iff (arst)
      (apre && eff_mode != 2'd0) |-> (fb_out == 1'b1));

   generate
      if (BURIED) begin : g_bur_chk
         p_no_drive_r10: assert property (@(posedge clk) disable iff (arst)
            (1'b1) |-> (!pin_oe && !pin_out));
      end else begin : g_pin_chk
         p_pin_mirror_r9: assert property (@(posedge clk) disable iff (arst)
            (1'b1) |-> (pin_out == fb_out));
      end
   endgenerate
endmodule

bind lgc_macrocell mc_checker #(
   .N_TERMS(N_TERMS),
   .N_GCLK (N_GCLK),
   .BURIED (BURIED)
) u_chk (.*);

// File: tb/lgc_macrocell_tb_top.sv
module lgc_macrocell_tb_top;
   localparam int CLK_P = 10;

   typedef struct {
      logic  e_fb;
      logic  e_oe;
      logic  e_bfb;
      string tag;
   } item_t;

   logic        clk = 1'b0;
   logic        arst = 1'b1;
   logic        apre = 1'b0;
   logic [15:0] pterms = '0;
   logic [1:0]  gclk_en = '0;
   logic        oe_term = 1'b0;
   logic        pin_in = 1'b0;
   logic [15:0] cfg_term_mask = '0;
   logic        cfg_invert = 1'b0;
   logic [1:0]  cfg_mode = 2'd1;
   logic [0:0]  cfg_clk_sel = '0;
   logic        cfg_inreg = 1'b0;
   logic        cfg_inreg_latch = 1'b0;
   logic        io_pin, io_oe, io_fb;
   logic        bu_pin, bu_oe, bu_fb;

   item_t sb[$];
   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   lgc_macrocell #(.N_TERMS(16), .N_GCLK(2), .BURIED(1'b0)) dut_i (
      .clk(clk), .arst(arst), .apre(apre), .pterms(pterms), .gclk_en(gclk_en),
      .oe_term(oe_term), .pin_in(pin_in), .cfg_term_mask(cfg_term_mask),
      .cfg_invert(cfg_invert), .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
      .cfg_inreg(cfg_inreg), .cfg_inreg_latch(cfg_inreg_latch),
      .pin_out(io_pin), .pin_oe(io_oe), .fb_out(io_fb)
   );

   lgc_macrocell #(.N_TERMS(16), .N_GCLK(2), .BURIED(1'b1)) dut_b_i (
      .clk(clk), .arst(arst), .apre(apre), .pterms(pterms), .gclk_en(gclk_en),
      .oe_term(oe_term), .pin_in(pin_in), .cfg_term_mask(cfg_term_mask),
      .cfg_invert(cfg_invert), .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
      .cfg_inreg(cfg_inreg), .cfg_inreg_latch(cfg_inreg_latch),
      .pin_out(bu_pin), .pin_oe(bu_oe), .fb_out(bu_fb)
   );

   task automatic chk(input logic act, input logic exp, input string what, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
      end
   endtask

   // monitor: pops one expected item per rising edge, after the edge settles
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            chk(io_fb,  it.e_fb,  "pin-variant fb_out", it.tag);
            chk(io_pin, it.e_fb,  "R9 pin_out mirrors state", it.tag);
            chk(io_oe,  it.e_oe,  "R9 pin_oe follows oe_term", it.tag);
            chk(bu_fb,  it.e_bfb, "buried fb_out", it.tag);
            chk(bu_pin, 1'b0,     "R10 buried pin_out", it.tag);
            chk(bu_oe,  1'b0,     "R10 buried pin_oe", it.tag);
         end
      end
   end

   // driver: drive at the falling edge, queue what the next rising edge must show
   task automatic step(input logic [15:0] pt, input logic [1:0] ge, input logic r,
                       input logic p, input logic oe, input logic pi,
                       input logic efb, input logic ebfb, input string tag);
      @(negedge clk);
      pterms = pt; gclk_en = ge; arst = r; apre = p; oe_term = oe; pin_in = pi;
      sb.push_back('{e_fb: efb, e_oe: oe, e_bfb: ebfb, tag: tag});
   endtask

   task automatic cfg(input logic [15:0] mask, input logic inv, input logic [1:0] mode,
                      input logic sel, input logic inreg, input logic inlat,
                      input logic efb, input logic ebfb, input string tag);
      @(negedge clk);
      arst = 1'b1; apre = 1'b0; pterms = '0; gclk_en = '0; oe_term = 1'b0; pin_in = 1'b0;
      cfg_term_mask = mask; cfg_invert = inv; cfg_mode = mode; cfg_clk_sel = sel;
      cfg_inreg = inreg; cfg_inreg_latch = inlat;
      sb.push_back('{e_fb: efb, e_oe: 1'b0, e_bfb: ebfb, tag: tag});
   endtask

   initial begin
      // D flip-flop, enable 0
      cfg(16'h000F, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 reset clears");
      step(16'h0001, 2'b01, 0, 0, 1, 0, 1, 1, "R4 load one");
      step(16'h0000, 2'b00, 0, 0, 0, 0, 1, 1, "R4 hold with pin off R9");
      step(16'h0000, 2'b10, 0, 0, 1, 0, 1, 1, "R7 unselected enable");
      step(16'h0000, 2'b01, 0, 0, 0, 0, 0, 0, "R4 load zero R9");
      step(16'h0010, 2'b01, 0, 0, 1, 0, 0, 0, "R1 unmasked term");
      step(16'h0008, 2'b01, 0, 0, 1, 0, 1, 1, "R1 masked term");
      step(16'h0000, 2'b01, 0, 0, 1, 0, 0, 0, "R4 load zero");
      step(16'h0000, 2'b00, 0, 1, 1, 0, 1, 1, "R8 async set");
      step(16'h0000, 2'b00, 0, 0, 1, 0, 1, 1, "R8 set retained");
      step(16'h0000, 2'b00, 1, 1, 1, 0, 0, 0, "R8 clear beats set");
      step(16'h0000, 2'b00, 0, 0, 1, 0, 0, 0, "R8 clear retained");
      // T flip-flop, inverted, enable 1
      cfg(16'h0003, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 reset T");
      step(16'h0000, 2'b10, 0, 0, 1, 0, 1, 1, "R5 R2 toggle on inverted zero");
      step(16'h0001, 2'b10, 0, 0, 1, 0, 1, 1, "R5 hold on zero data");
      step(16'h0000, 2'b10, 0, 0, 1, 0, 0, 0, "R5 toggle back");
      step(16'h0000, 2'b01, 0, 0, 1, 0, 0, 0, "R7 other enable in T");
      step(16'h0004, 2'b10, 0, 0, 1, 0, 1, 1, "R1 R5 masked-out term");
      // latch, enable 0
      cfg(16'hFFFF, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 reset latch");
      step(16'h8000, 2'b01, 0, 0, 1, 0, 1, 1, "R6 transparent high");
      step(16'h0000, 2'b01, 0, 0, 1, 0, 0, 0, "R6 transparent low");
      step(16'h0001, 2'b01, 0, 0, 1, 0, 1, 1, "R6 transparent high again");
      step(16'h0000, 2'b00, 0, 0, 1, 0, 1, 1, "R6 closed holds");
      step(16'h0000, 2'b10, 0, 0, 1, 0, 1, 1, "R7 latch other enable");
      step(16'h0000, 2'b01, 0, 0, 1, 0, 0, 0, "R6 reopen");
      step(16'hFFFF, 2'b01, 1, 0, 1, 0, 0, 0, "R8 clear over open latch");
      step(16'hFFFF, 2'b01, 0, 0, 1, 0, 1, 1, "R6 open after clear");
      // wire mode
      cfg(16'h0000, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 R1 wire ignores clear");
      step(16'hFFFF, 2'b00, 0, 0, 1, 0, 1, 1, "R1 empty mask");
      cfg(16'h00F0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 wire zero");
      step(16'h0010, 2'b00, 0, 0, 1, 0, 1, 1, "R3 wire follows");
      step(16'h0020, 2'b01, 1, 0, 1, 0, 1, 1, "R3 clear has no effect");
      step(16'h0000, 2'b00, 0, 1, 1, 0, 0, 0, "R3 set has no effect");
      step(16'h0000, 2'b00, 0, 0, 1, 0, 0, 0, "R3 wire low");
      // input register (buried) vs ignored (pin variant)
      cfg(16'hFFFF, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 reset inreg");
      step(16'h0000, 2'b01, 0, 0, 1, 0, 1, 0, "R11 R12 pin value not inverted");
      step(16'hFFFF, 2'b01, 0, 0, 1, 1, 0, 1, "R11 R12 pin value loaded");
      step(16'h0000, 2'b00, 0, 0, 1, 0, 0, 1, "R11 input register holds");
      cfg(16'hFFFF, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R8 reset inlatch");
      step(16'h0000, 2'b01, 0, 0, 1, 1, 0, 1, "R11 input latch open");
      step(16'h0001, 2'b00, 0, 0, 1, 0, 0, 1, "R11 input latch closed");
      step(16'h0001, 2'b01, 0, 0, 1, 0, 1, 0, "R11 R12 input latch reopen");
      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end
endmodule